// File: doc/BRIEF.md
# Dual Card Channel Selector

This block connects a single host-side card interface (an open-drain data line, a reset input and a card clock input) to one of two card sockets. A channel select input chooses which socket talks to the host. The two socket channels can both be enabled and powered at once, so the host can switch between them without waiting for a new activation. Each channel also has a sequencer that reports when the channel is ready, and this block uses that flag to gate every path belonging to the channel.

The data line is modelled as separate drive-low and sense signals. A low asserted by the host on the selected path is repeated towards the socket. A low asserted by the selected socket is repeated towards the host. A socket that is not selected is released, which means high, and it is cut off from the host line. Each socket's reset follows the host reset while the socket is selected. When the socket is deselected, its last reset level is held, so the card stays initialised. Each socket's clock is a gated copy of the host clock. A clock-run control can keep a deselected socket clocked. The select and clock-run inputs, and the host clock itself, are synchronized to the block clock. The clock gate only changes while the synchronized host clock is low.

Top module: `card_chan_select`

## Requirements
- R1: A select value of 0 routes the data path to socket 0 and a value of 1 routes it to socket 1. Only the selected socket's `sock_dat_pull` bit can ever be high.
- R2: Both channels may be active at the same time. Changing `chan_sel` moves the data route to the other socket `SYNC_STAGES` clock cycles later, with no change on `seq_active`.
- R3: On the selected, active channel, `host_dat_low`=1 sets that socket's `sock_dat_pull` bit in the same cycle. That socket's `sock_dat_low` bit=1 sets `host_dat_pull` in the same cycle.
- R4: For a socket that is not selected, `sock_dat_pull` stays 0, and its `sock_dat_low` bit has no effect on `host_dat_pull`.
- R5: When no bit of `seq_active` is set, `host_dat_pull` and every `sock_dat_pull` bit are 0.
- R6: On the selected, active channel, `sock_rst` equals `host_rst` in the same cycle.
- R7: When an active socket is deselected, its `sock_rst` keeps the `host_rst` level it had while it was last selected. Later changes on `host_rst` do not change it.
- R8: While a channel's `seq_active` bit is 0, its `sock_rst`, `sock_dat_pull` and `sock_clk` bits are 0. `sock_clk` goes to 0 by the next cycle.
- R9: When an active, enabled socket without clock-run is deselected, its `sock_clk` is low and stays low no later than two host clock periods after the synchronized select changes.
- R10: If a channel is active, its `chan_en` bit is 1 and its `clk_keep` bit is 1, its socket receives the host clock whatever the value of `chan_sel`. With `chan_en` at 0 it receives no clock.
- R11: A change in select or clock-run never shortens a `sock_clk` high pulse. Every high pulse lasts as long as the synchronized host clock's high phase.
- R12: During reset, `sock_clk`, `sock_rst`, `sock_dat_pull` and `host_dat_pull` are 0 (with `seq_active` at 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; samples the host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_sel | input | SEL_W | Socket index that owns the host data path (0 or 1) |
| chan_en | input | NUM_CH | Per-channel enable; bit 0 is socket 0 |
| clk_keep | input | NUM_CH | Per-channel clock-run control |
| seq_active | input | NUM_CH | Per-channel sequencer ready flag |
| host_clk | input | 1 | Host card clock, slower than clk |
| host_rst | input | 1 | Host card reset level |
| host_dat_low | input | 1 | Host is pulling the data line low |
| host_dat_pull | output | 1 | Block pulls the host data line low |
| sock_dat_low | input | NUM_CH | Socket is pulling its I/O line low |
| sock_dat_pull | output | NUM_CH | Block pulls the socket I/O line low |
| sock_rst | output | NUM_CH | Reset level driven to each socket |
| sock_clk | output | NUM_CH | Gated clock driven to each socket |

## Verification
The bench builds the block with `NUM_CH`=2 and `SYNC_STAGES`=3. The three-stage setting shows that the select latency and the clock-stop window follow the parameter and are not fixed at the default of two. The host clock has a half period of four block cycles. This makes the length of each gated high pulse measurable, so select toggles placed at several phase offsets can show that no pulse is cut short. Two sockets are enough to cover dual activation, switching, latched resets and clock-run on the deselected side.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int unsigned SOCK_0 = 0;
  localparam int unsigned SOCK_1 = 1;

  function automatic int unsigned sel_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ccs_sync.sv
module ccs_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ccs_clk_gate.sv
module ccs_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic hclk_s,
  input  logic active,
  input  logic enable,
  input  logic selected,
  input  logic keep,
  output logic sock_clk
);
  logic gate_q;
  logic want;
  logic gate_next;

  // The socket wants the clock when it is ready and is either selected or kept running.
  assign want = active & enable & (selected | keep);

  // The gate only moves while the host clock is low. Deactivation overrides this.
  always_comb begin
    if (!active)      gate_next = 1'b0;
    else if (hclk_s)  gate_next = gate_q;
    else              gate_next = want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q   <= 1'b0;
      sock_clk <= 1'b0;
    end else begin
      gate_q   <= gate_next;
      sock_clk <= hclk_s & gate_next;
    end
  end
endmodule

// File: rtl/ccs_rst_hold.sv
module ccs_rst_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic routed,
  input  logic host_rst,
  output logic sock_rst
);
  logic held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= 1'b0;
    else if (!active) held_q <= 1'b0;
    else if (routed)  held_q <= host_rst;
  end

  always_comb begin
    if (!active)     sock_rst = 1'b0;
    else if (routed) sock_rst = host_rst;
    else             sock_rst = held_q;
  end
endmodule

// File: rtl/ccs_data_route.sv
module ccs_data_route #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] route,
  input  logic              host_dat_low,
  input  logic [NUM_CH-1:0] sock_dat_low,
  output logic [NUM_CH-1:0] sock_dat_pull,
  output logic              host_dat_pull
);
  assign sock_dat_pull = route & {NUM_CH{host_dat_low}};
  assign host_dat_pull = |(route & sock_dat_low);
endmodule

// File: rtl/card_chan_select.sv
module card_chan_select
  import ccs_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W      = sel_bits(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  chan_sel,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [NUM_CH-1:0] clk_keep,
  input  logic [NUM_CH-1:0] seq_active,
  input  logic              host_clk,
  input  logic              host_rst,
  input  logic              host_dat_low,
  output logic              host_dat_pull,
  input  logic [NUM_CH-1:0] sock_dat_low,
  output logic [NUM_CH-1:0] sock_dat_pull,
  output logic [NUM_CH-1:0] sock_rst,
  output logic [NUM_CH-1:0] sock_clk
);
  localparam int unsigned CTRL_W = SEL_W + NUM_CH;

  logic [SEL_W-1:0]  sel_s;
  logic [NUM_CH-1:0] keep_s;
  logic              hclk_s;
  logic [NUM_CH-1:0] route;

  ccs_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_ctrl_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({chan_sel, clk_keep}),
    .q     ({sel_s, keep_s})
  );

  ccs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_hclk_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (host_clk),
    .q     (hclk_s)
  );

  ccs_data_route #(.NUM_CH(NUM_CH)) u_route (
    .route         (route),
    .host_dat_low  (host_dat_low),
    .sock_dat_low  (sock_dat_low),
    .sock_dat_pull (sock_dat_pull),
    .host_dat_pull (host_dat_pull)
  );

  for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
    assign route[c] = (sel_s == SEL_W'(c)) && seq_active[c];

    ccs_rst_hold u_rst (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (seq_active[c]),
      .routed   (route[c]),
      .host_rst (host_rst),
      .sock_rst (sock_rst[c])
    );

    ccs_clk_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .hclk_s   (hclk_s),
      .active   (seq_active[c]),
      .enable   (chan_en[c]),
      .selected (sel_s == SEL_W'(c)),
      .keep     (keep_s[c]),
      .sock_clk (sock_clk[c])
    );
  end
endmodule

// File: rtl/card_chan_select_chk.sv
module card_chan_select_chk
  import ccs_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned SEL_W = sel_bits(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  sel_s,
  input logic              hclk_s,
  input logic [NUM_CH-1:0] seq_active,
  input logic              host_rst,
  input logic              host_dat_low,
  input logic              host_dat_pull,
  input logic [NUM_CH-1:0] sock_dat_low,
  input logic [NUM_CH-1:0] sock_dat_pull,
  input logic [NUM_CH-1:0] sock_rst,
  input logic [NUM_CH-1:0] sock_clk
);
  AST_ONE_SOCKET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sock_dat_pull) <= 1); // R1

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active == '0) |-> (!host_dat_pull && sock_dat_pull == '0)); // R5

  for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_chk
    logic on_path;
    assign on_path = (sel_s == SEL_W'(c)) && seq_active[c];

    AST_HOST_TO_SOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (on_path && host_dat_low) |-> sock_dat_pull[c]); // R3

    AST_SOCK_TO_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      (on_path && sock_dat_low[c]) |-> host_dat_pull); // R3

    AST_UNSEL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !on_path |-> !sock_dat_pull[c]); // R4

    AST_RST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      on_path |-> (sock_rst[c] == host_rst)); // R6

    AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_active[c] && $past(seq_active[c]) && !on_path && !$past(on_path))
        |-> $stable(sock_rst[c])); // R7

    AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_active[c] |-> (!sock_rst[c] && !sock_dat_pull[c])); // R8

    AST_INACTIVE_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_active[c] |=> !sock_clk[c]); // R8

    AST_NO_TRUNCATE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sock_clk[c]) && $past(seq_active[c])) |-> !$past(hclk_s)); // R11
  end
endmodule

bind card_chan_select card_chan_select_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sel_s         (sel_s),
  .hclk_s        (hclk_s),
  .seq_active    (seq_active),
  .host_rst      (host_rst),
  .host_dat_low  (host_dat_low),
  .host_dat_pull (host_dat_pull),
  .sock_dat_low  (sock_dat_low),
  .sock_dat_pull (sock_dat_pull),
  .sock_rst      (sock_rst),
  .sock_clk      (sock_clk)
);

// File: tb/card_chan_select_bench.sv
module card_chan_select_bench;
  localparam int unsigned NCH  = 2;
  localparam int unsigned SYNC = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [0:0]     chan_sel = '0;
  logic [NCH-1:0] chan_en = '0;
  logic [NCH-1:0] clk_keep = '0;
  logic [NCH-1:0] seq_active = '0;
  logic           host_clk = 1'b0;
  logic           host_rst = 1'b0;
  logic           host_dat_low = 1'b0;
  logic           host_dat_pull;
  logic [NCH-1:0] sock_dat_low = '0;
  logic [NCH-1:0] sock_dat_pull;
  logic [NCH-1:0] sock_rst;
  logic [NCH-1:0] sock_clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always #40 host_clk = ~host_clk;

  card_chan_select #(.NUM_CH(NCH), .SYNC_STAGES(SYNC)) u_card_chan_select (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .chan_en(chan_en),
    .clk_keep(clk_keep), .seq_active(seq_active), .host_clk(host_clk),
    .host_rst(host_rst), .host_dat_low(host_dat_low), .host_dat_pull(host_dat_pull),
    .sock_dat_low(sock_dat_low), .sock_dat_pull(sock_dat_pull),
    .sock_rst(sock_rst), .sock_clk(sock_clk)
  );

  // Pulse-length monitor for gated clocks
  bit mon_on = 1'b0;
  bit seen [NCH];
  int run [NCH];
  int pulses = 0;
  int bad = 0;
  logic [NCH-1:0] mon_prev = '0;

  always @(negedge clk) begin
    for (int c = 0; c < int'(NCH); c++) begin
      if (!mon_on) begin
        seen[c] = 1'b0;
        run[c] = 0;
      end else if (sock_clk[c] && !mon_prev[c]) begin
        seen[c] = 1'b1;
        run[c] = 1;
      end else if (sock_clk[c]) begin
        run[c]++;
      end else if (mon_prev[c] && seen[c]) begin
        pulses++;
        if (run[c] != 4) bad++;
        seen[c] = 1'b0;
      end
    end
    mon_prev = sock_clk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_rises(input int ch, input int n, output int r);
    logic prev;
    r = 0;
    prev = sock_clk[ch];
    repeat (n) begin
      @(negedge clk);
      if (sock_clk[ch] && !prev) r++;
      prev = sock_clk[ch];
    end
  endtask

  task automatic setup(input logic s, input logic [NCH-1:0] en,
                       input logic [NCH-1:0] act, input logic [NCH-1:0] keep);
    @(negedge clk);
    chan_sel = s; chan_en = en; seq_active = act; clk_keep = keep;
    host_dat_low = 1'b0; sock_dat_low = '0;
    wait_neg(SYNC + 3);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    wait_neg(10);
    chk("R12 sock_clk in reset", 32'(sock_clk), 0);
    chk("R12 sock_rst in reset", 32'(sock_rst), 0);
    chk("R12 sock_dat_pull in reset", 32'(sock_dat_pull), 0);
    chk("R12 host_dat_pull in reset", 32'(host_dat_pull), 0);
    rst_n = 1'b1;
    wait_neg(2);
  endtask

  task automatic t_route_a;
    setup(1'b0, 2'b01, 2'b01, 2'b00);
    host_dat_low = 1'b1; #1;
    chk("R1 select 0 drives socket 0", 32'(sock_dat_pull), 32'b01);
    chk("R3 host low reaches socket 0", 32'(sock_dat_pull[0]), 1);
    @(negedge clk); host_dat_low = 1'b0; sock_dat_low = 2'b01; #1;
    chk("R3 socket 0 low reaches host", 32'(host_dat_pull), 1);
    @(negedge clk); sock_dat_low = '0; #1;
    chk("R3 host released", 32'(host_dat_pull), 0);
  endtask

  task automatic t_route_b;
    setup(1'b1, 2'b11, 2'b11, 2'b00);
    host_dat_low = 1'b1; #1;
    chk("R1 select 1 drives socket 1", 32'(sock_dat_pull), 32'b10);
    @(negedge clk); host_dat_low = 1'b0; sock_dat_low = 2'b10; #1;
    chk("R3 socket 1 low reaches host", 32'(host_dat_pull), 1);
    @(negedge clk); sock_dat_low = '0;
  endtask

  task automatic t_unsel;
    setup(1'b1, 2'b11, 2'b11, 2'b00);
    sock_dat_low = 2'b01; #1;
    chk("R4 unselected socket low ignored", 32'(host_dat_pull), 0);
    @(negedge clk); sock_dat_low = '0; host_dat_low = 1'b1; #1;
    chk("R4 unselected socket released", 32'(sock_dat_pull[0]), 0);
    @(negedge clk); host_dat_low = 1'b0;
  endtask

  task automatic t_idle;
    setup(1'b0, 2'b00, 2'b00, 2'b00);
    sock_dat_low = 2'b11; host_dat_low = 1'b1; #1;
    chk("R5 idle host released", 32'(host_dat_pull), 0);
    chk("R5 idle sockets released", 32'(sock_dat_pull), 0);
    @(negedge clk); sock_dat_low = '0; host_dat_low = 1'b0;
  endtask

  task automatic t_switch;
    setup(1'b1, 2'b11, 2'b11, 2'b00);
    host_dat_low = 1'b1; #1;
    chk("R2 before switch socket 1 routed", 32'(sock_dat_pull), 32'b10);
    @(negedge clk); chan_sel = 1'b0;
    wait_neg(SYNC + 1); #1;
    chk("R2 after switch socket 0 routed", 32'(sock_dat_pull), 32'b01);
    @(negedge clk); host_dat_low = 1'b0;
  endtask

  task automatic t_rst;
    setup(1'b0, 2'b11, 2'b11, 2'b00);
    host_rst = 1'b1; #1;
    chk("R6 selected reset high", 32'(sock_rst[0]), 1);
    @(negedge clk); host_rst = 1'b0; #1;
    chk("R6 selected reset low", 32'(sock_rst[0]), 0);
    @(negedge clk); host_rst = 1'b1;
    wait_neg(2);
    chan_sel = 1'b1;
    wait_neg(SYNC + 2);
    host_rst = 1'b0; #1;
    chk("R7 deselected reset held high", 32'(sock_rst[0]), 1);
    chk("R6 newly selected follows", 32'(sock_rst[1]), 0);
    wait_neg(3); host_rst = 1'b1; wait_neg(1); host_rst = 1'b0; #1;
    chk("R7 held after host toggles", 32'(sock_rst[0]), 1);
  endtask

  task automatic t_inactive;
    int r;
    setup(1'b0, 2'b01, 2'b00, 2'b01);
    host_rst = 1'b1; host_dat_low = 1'b1; #1;
    chk("R8 inactive reset low", 32'(sock_rst[0]), 0);
    chk("R8 inactive data released", 32'(sock_dat_pull[0]), 0);
    count_rises(0, 24, r);
    chk("R8 inactive no clock", 32'(r), 0);
    host_rst = 1'b0; host_dat_low = 1'b0;
  endtask

  task automatic t_clk_stop;
    int r;
    setup(1'b0, 2'b11, 2'b11, 2'b00);
    count_rises(0, 24, r);
    chk("R9 selected socket clocked", 32'(r > 0), 1);
    chan_sel = 1'b1;
    wait_neg(SYNC + 16);
    chk("R9 deselected clock low", 32'(sock_clk[0]), 0);
    count_rises(0, 32, r);
    chk("R9 deselected clock stays low", 32'(r), 0);
    count_rises(1, 24, r);
    chk("R9 new socket clocked", 32'(r > 0), 1);
  endtask

  task automatic t_clk_run;
    int r;
    setup(1'b1, 2'b11, 2'b11, 2'b01);
    wait_neg(16);
    count_rises(0, 24, r);
    chk("R10 clock-run on deselected socket", 32'(r > 0), 1);
    count_rises(1, 24, r);
    chk("R2 both sockets clocked", 32'(r > 0), 1);
    chan_en = 2'b10;
    wait_neg(SYNC + 16);
    count_rises(0, 24, r);
    chk("R10 disabled channel not clocked", 32'(r), 0);
  endtask

  task automatic t_no_trunc;
    setup(1'b0, 2'b11, 2'b11, 2'b00);
    mon_on = 1'b1;
    for (int k = 0; k < 8; k++) begin
      chan_sel = k[0];
      wait_neg(7 + k);
    end
    clk_keep = 2'b10;
    wait_neg(9);
    clk_keep = 2'b00;
    wait_neg(20);
    mon_on = 1'b0;
    @(negedge clk);
    chk("R11 no truncated pulses", 32'(bad), 0);
    chk("R11 pulses observed", 32'(pulses > 0), 1);
  endtask

  initial begin
    t_reset();
    t_route_a();
    t_route_b();
    t_unsel();
    t_idle();
    t_switch();
    t_rst();
    t_inactive();
    t_clk_stop();
    t_clk_run();
    t_no_trunc();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule